// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This unit holds an 8-bit accumulator and a five-bit status word. On each cycle where the valid strobe is high, it applies one operation. The operation combines the accumulator with an 8-bit operand. That operand may come from a register, a memory byte or an immediate field, but this unit does not care which. The result and the new flags are captured on that clock edge. Every operation has its own rule for which flags it writes. The arithmetic group writes all five flags. The logical group forces the two carry flags to fixed values. The rotates touch only the carry. Complement-accumulator touches no flag at all.

The operation arrives already decoded as a 4-bit select. Register-file addressing, memory access and instruction decode live outside this unit. The decimal-adjust operation reads the two carry flags left by a previous addition. It uses them to turn a binary sum of two packed BCD bytes back into packed BCD.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rst_n` is low, and until the first strobed operation after its release, `acc_o` and `flags_o` read zero. The flag word is laid out as bit 4 sign, bit 3 zero, bit 2 half-carry, bit 1 parity, bit 0 carry.
- R2: When `valid_i` is low, neither `acc_o` nor `flags_o` changes, whatever `op_i` and `operand_i` carry.
- R3: `op_i` 0 (add) and 1 (add with carry) load A + operand, plus the current carry for code 1. The carry flag is the carry out of bit 7, and the half-carry flag is the carry out of bit 3. Both results are captured on the edge where `valid_i` is high.
- R4: Codes 2 (subtract) and 3 (subtract with borrow) load A − operand, minus the carry for code 3, in two's complement. The carry flag is set when operand plus borrow-in exceeds A. The half-carry flag is set when the low nibble of the operand plus borrow-in exceeds the low nibble of A.
- R5: For every code that writes the accumulator and updates all flags (0–6, 15), sign equals result bit 7, zero is set for an all-zero result, and parity is set when the result has an even count of ones.
- R6: Code 4 (AND) sets half-carry and clears carry. Codes 5 (XOR) and 6 (OR) clear both half-carry and carry.
- R7: Code 7 (compare) leaves the accumulator unchanged. It sets the flags as a subtraction would. Carry is set when A < operand, zero is set when they are equal, and both are clear when A > operand.
- R8: Code 8 rotates left, moving bit 7 into bit 0 and into carry. Code 9 rotates right, moving bit 0 into bit 7 and into carry. Neither changes sign, zero, half-carry or parity.
- R9: Code 10 rotates left through carry: bit 7 goes to carry and the old carry to bit 0. Code 11 rotates right through carry: bit 0 goes to carry and the old carry to bit 7. No other flag changes.
- R10: Code 12 inverts the accumulator and keeps every flag. Code 13 inverts carry and code 14 sets carry. Both leave the accumulator and the other flags as they were.
- R11: Code 15 (decimal adjust) adds 6 when the low nibble exceeds 9 or half-carry is set. It then adds 0x60 when the resulting high nibble exceeds 9, or carry is set, or the first step carried out. Carry becomes 1 when that second correction applies and otherwise keeps its old value. Half-carry is the carry out of bit 3 from the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Strobe: apply `op_i` on this edge |
| op_i | input | 4 | Operation select (codes in R3–R11) |
| operand_i | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | Status flags {sign, zero, half-carry, parity, carry} |

## Verification
The accumulator is loaded through AND-with-zero followed by OR-with-value. Addition is then tried without any carry, with a carry out of bit 7 only, and with a carry out of bit 3 only, which separates the two carry detectors. Subtraction and compare are driven with operands below, equal to and above the accumulator, so borrow, zero and the unchanged-accumulator rule are each told apart. Rotates are applied with carry both set and clear, which separates plain rotates from rotates through carry. Decimal adjust is run once on a sum that needs only the low correction and once on a sum where the high correction comes from the carry flag alone.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FW = 5;
  localparam int OPW = 4;
  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [DW-1:0] LO_FIX = DW'(6);
  localparam logic [DW-1:0] HI_FIX = DW'(8'h60);

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8,
    OP_RRC = 4'd9,
    OP_RAL = 4'd10,
    OP_RAR = 4'd11,
    OP_CMA = 4'd12,
    OP_CMC = 4'd13,
    OP_STC = 4'd14,
    OP_DAA = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          carry_i,
  input  logic          sub_i,
  input  logic          use_carry_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);

  logic [DW-1:0] b_eff;
  logic          cin_raw;
  logic          cin_eff;
  logic [NW:0]   lo_sum;
  logic [DW:0]   full_sum;

  // Subtraction runs on the same adder: a + ~b + ~borrow.
  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    cin_raw  = use_carry_i & carry_i;
    cin_eff  = sub_i ? ~cin_raw : cin_raw;
    lo_sum   = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin_eff};
    full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
    res_o    = full_sum[DW-1:0];
    // A missing carry out on subtraction is a borrow.
    cy_o     = full_sum[DW] ^ sub_i;
    ac_o     = lo_sum[NW] ^ sub_i;
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    ac_o  = 1'b0;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; ac_o = 1'b1; end
      OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
      OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
      OP_CMA: res_o = ~a_i;
      OP_CMC: cy_o = ~cy_i;
      OP_STC: cy_o = 1'b1;
      default: begin
        res_o = a_i;
        cy_o  = cy_i;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);

  logic        lo_fix;
  logic        hi_fix;
  logic [DW:0] step1;
  logic [DW:0] step2;

  always_comb begin
    lo_fix = (a_i[NW-1:0] > NIB_MAX) | ac_i;
    step1  = {1'b0, a_i} + {1'b0, (lo_fix ? LO_FIX : '0)};
    // The low step carries out of bit 3 only when the nibble was above 9.
    ac_o   = lo_fix & (a_i[NW-1:0] > NIB_MAX);
    hi_fix = (step1[DW-1:NW] > NIB_MAX) | cy_i | step1[DW];
    step2  = {1'b0, step1[DW-1:0]} + {1'b0, (hi_fix ? HI_FIX : '0)};
    res_o  = step2[DW-1:0];
    cy_o   = hi_fix;
  end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  operand_i,
  output logic [DW-1:0]  acc_o,
  output logic [FW-1:0]  flags_o
);

  logic          srst_n;
  alu_op_e       op;
  logic [DW-1:0] acc_q, acc_nxt;
  flags_t        flg_q, flg_nxt;

  logic          ar_sub, ar_usec;
  logic [DW-1:0] ar_res;
  logic          ar_cy, ar_ac;
  logic [DW-1:0] lg_res;
  logic          lg_cy, lg_ac;
  logic [DW-1:0] bc_res;
  logic          bc_cy, bc_ac;

  assign op = alu_op_e'(op_i);

  acc_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    ar_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    ar_usec = (op == OP_ADC) || (op == OP_SBB);
  end

  acc_alu_arith u_arith (
    .a_i         (acc_q),
    .b_i         (operand_i),
    .carry_i     (flg_q.cy),
    .sub_i       (ar_sub),
    .use_carry_i (ar_usec),
    .res_o       (ar_res),
    .cy_o        (ar_cy),
    .ac_o        (ar_ac)
  );

  acc_alu_logic u_logic (
    .op_i  (op),
    .a_i   (acc_q),
    .b_i   (operand_i),
    .cy_i  (flg_q.cy),
    .res_o (lg_res),
    .cy_o  (lg_cy),
    .ac_o  (lg_ac)
  );

  acc_alu_bcd u_bcd (
    .a_i   (acc_q),
    .ac_i  (flg_q.ac),
    .cy_i  (flg_q.cy),
    .res_o (bc_res),
    .cy_o  (bc_cy),
    .ac_o  (bc_ac)
  );

  function automatic flags_t full_flags(input logic [DW-1:0] r,
                                        input logic ac, input logic cy);
    flags_t f;
    f.s  = r[DW-1];
    f.z  = (r == '0);
    f.ac = ac;
    f.p  = ~^r;
    f.cy = cy;
    return f;
  endfunction

  // Next state: pick the result source and which flags it may write.
  always_comb begin
    acc_nxt = acc_q;
    flg_nxt = flg_q;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_nxt = ar_res;
        flg_nxt = full_flags(ar_res, ar_ac, ar_cy);
      end
      OP_CMP: flg_nxt = full_flags(ar_res, ar_ac, ar_cy);
      OP_AND, OP_XOR, OP_OR: begin
        acc_nxt = lg_res;
        flg_nxt = full_flags(lg_res, lg_ac, lg_cy);
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_nxt    = lg_res;
        flg_nxt.cy = lg_cy;
      end
      OP_CMA: acc_nxt = lg_res;
      OP_CMC, OP_STC: flg_nxt.cy = lg_cy;
      OP_DAA: begin
        acc_nxt = bc_res;
        flg_nxt = full_flags(bc_res, bc_ac, bc_cy);
      end
      default: begin
        acc_nxt = acc_q;
        flg_nxt = flg_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (valid_i) begin
      acc_q <= acc_nxt;
      flg_q <= flg_nxt;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flg_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !valid_i |=> ($stable(acc_q) && $stable(flg_q)));

  assert_szp_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && (op_i <= 4'd6 || op_i == 4'd15)) |=>
      (flg_q.p == ~^acc_q) && (flg_q.z == (acc_q == '0)) && (flg_q.s == acc_q[DW-1]));

  assert_and_flags_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && op_i == 4'd4) |=> (flg_q.ac && !flg_q.cy));

  assert_orxor_flags_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && (op_i == 4'd5 || op_i == 4'd6)) |=> (!flg_q.ac && !flg_q.cy));

  assert_cmp_keep_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && op_i == 4'd7) |=> $stable(acc_q));

  assert_rot_flags_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && op_i[3:2] == 2'b10) |=>
      ({flg_q.s, flg_q.z, flg_q.ac, flg_q.p} == $past({flg_q.s, flg_q.z, flg_q.ac, flg_q.p})));

  assert_cma_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && op_i == 4'd12) |=> (acc_q == ~$past(acc_q)) && $stable(flg_q));

  assert_stc_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_i && op_i == 4'd14) |=> (flg_q.cy && $stable(acc_q)));

endmodule

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;

  logic       clk;
  logic       rst_n;
  logic       valid_i;
  logic [3:0] op_i;
  logic [7:0] operand_i;
  logic [7:0] acc_o;
  logic [4:0] flags_o;

  acc_alu_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .operand_i (operand_i),
    .acc_o     (acc_o),
    .flags_o   (flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [7:0] acc;
    logic [4:0] flg;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         n_checks = 0;
  int         n_fail   = 0;
  logic       pend;
  logic       done = 1'b0;
  logic [7:0] m_acc;
  logic [4:0] m_flg;

  function automatic logic [12:0] model(input int op, input logic [7:0] a8,
                                        input logic [7:0] b8, input logic [4:0] f);
    int a, b, v, cin, lo;
    logic [7:0] r;
    logic s, z, ac, p, cy, setall;
    a = int'(a8); b = int'(b8);
    r = a8; ac = f[2]; cy = f[0]; setall = 1'b0;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(f[0]) : 0;
        v = a + b + cin;
        r = v[7:0]; cy = (v > 255); ac = ((a % 16) + (b % 16) + cin) > 15; setall = 1'b1;
      end
      2, 3, 7: begin
        cin = (op == 3) ? int'(f[0]) : 0;
        v = a - b - cin;
        cy = (b + cin) > a; ac = ((b % 16) + cin) > (a % 16); setall = 1'b1;
        r = (op == 7) ? a8 : v[7:0];
        if (op == 7) begin
          s = v[7]; z = (v[7:0] == 8'h00); p = ($countones(v[7:0]) % 2) == 0;
          return {a8, s, z, ac, p, cy};
        end
      end
      4: begin r = a8 & b8; ac = 1'b1; cy = 1'b0; setall = 1'b1; end
      5: begin r = a8 ^ b8; ac = 1'b0; cy = 1'b0; setall = 1'b1; end
      6: begin r = a8 | b8; ac = 1'b0; cy = 1'b0; setall = 1'b1; end
      8:  begin r = {a8[6:0], a8[7]}; cy = a8[7]; end
      9:  begin r = {a8[0], a8[7:1]}; cy = a8[0]; end
      10: begin r = {a8[6:0], f[0]};  cy = a8[7]; end
      11: begin r = {f[0], a8[7:1]};  cy = a8[0]; end
      12: r = ~a8;
      13: cy = ~f[0];
      14: cy = 1'b1;
      default: begin
        v = a; lo = a % 16;
        ac = 1'b0;
        if (lo > 9 || f[2]) begin v = v + 6; ac = (lo + 6) > 15; end
        if ((v / 16) > 9 || f[0]) begin v = v + 96; cy = 1'b1; end
        r = v[7:0]; setall = 1'b1;
      end
    endcase
    if (setall) begin
      s = r[7]; z = (r == 8'h00); p = ($countones(r) % 2) == 0;
    end else begin
      s = f[4]; z = f[3]; p = f[1];
    end
    return {r, s, z, ac, p, cy};
  endfunction

  task automatic apply(input int op, input logic [7:0] b, input string tag);
    logic [12:0] m;
    exp_t e;
    m = model(op, m_acc, b, m_flg);
    m_acc = m[12:5]; m_flg = m[4:0];
    e.acc = m_acc; e.flg = m_flg; e.tag = tag;
    sb_q.push_back(e);
    valid_i = 1'b1; op_i = op[3:0]; operand_i = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic check_now(input string tag);
    n_checks++;
    if (acc_o !== m_acc || flags_o !== m_flg) begin
      n_fail++;
      $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
               tag, acc_o, flags_o, m_acc, m_flg);
    end
  endtask

  always @(posedge clk) pend <= valid_i;

  always @(negedge clk) begin
    if (pend === 1'b1 && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (acc_o !== e.acc || flags_o !== e.flg) begin
        n_fail++;
        $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                 e.tag, acc_o, flags_o, e.acc, e.flg);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung (actual not done, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = 4'd0; operand_i = 8'h00;
    m_acc = 8'h00; m_flg = 5'b00000;
    repeat (3) @(negedge clk);
    check_now("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_now("R1 after release");

    apply(4, 8'h00, "R6 and-clear");
    apply(6, 8'h3A, "R6 or-load");
    apply(0, 8'h05, "R3 add plain");
    apply(0, 8'h08, "R3 add half-carry");
    apply(6, 8'hF0, "R6 or");
    apply(0, 8'h20, "R3 add carry-out");
    apply(1, 8'h01, "R3 adc with carry");
    apply(2, 8'h40, "R4 sub negative");
    apply(3, 8'h01, "R4 sbb with borrow");
    apply(5, 8'hFF, "R6 xor");
    apply(7, 8'hFF, "R7 cmp less");
    apply(7, m_acc, "R7 cmp equal");
    apply(7, 8'h00, "R7 cmp greater");
    apply(5, m_acc, "R5 xor-self zero");
    apply(6, 8'h96, "R5 or parity");

    // R2: strobe low, inputs wiggle, state must hold
    op_i = 4'd12; operand_i = 8'hAA;
    repeat (2) @(negedge clk);
    op_i = 4'd0; operand_i = 8'h55;
    @(negedge clk);
    check_now("R2 hold");

    apply(14, 8'h00, "R10 stc");
    apply(8, 8'h00, "R8 rlc");
    apply(9, 8'h00, "R8 rrc");
    apply(13, 8'h00, "R10 cmc");
    apply(10, 8'h00, "R9 ral carry0");
    apply(14, 8'h00, "R10 stc");
    apply(11, 8'h00, "R9 rar carry1");
    apply(10, 8'h00, "R9 ral");
    apply(12, 8'h00, "R10 cma");
    apply(13, 8'h00, "R10 cmc");

    apply(4, 8'h00, "R6 and-clear");
    apply(6, 8'h38, "R6 load");
    apply(0, 8'h45, "R3 bcd add");
    apply(15, 8'h00, "R11 daa low fix");
    apply(4, 8'h00, "R6 and-clear");
    apply(6, 8'h99, "R6 load");
    apply(0, 8'h99, "R3 bcd add carry");
    apply(15, 8'h00, "R11 daa carry fix");

    repeat (3) @(negedge clk);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 scoreboard: %0d left, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule